// File: doc/BRIEF.md
# Transmitter PHY Bring-Up Sequencer

This block takes a serial video-link transmitter PHY from power-down to a locked, transmitting state for a requested pixel clock. A single start pulse, together with a pixel clock given in kHz, launches a fixed program. The program drives the PHY's control pins one step per cycle, issues a list of 16-bit configuration writes through a request/acknowledge port towards the PHY's internal register bus, and then polls the PLL lock indicator. When all of this has run twice back to back, the block pulses `done`.

The values written depend on the band the pixel clock falls in. Every write waits for a completion or error flag, with a cycle-count timeout. The lock poll is also bounded. A write timeout, a lock failure or a pixel clock the PHY cannot run at ends the program with an `error` pulse and leaves PHY power and transmit power switched off. All timeouts are parameters in clock cycles, so that a bench can scale them down.

Top module: `phy_bringup_seq`

## Requirements
- R1: Reset state: after reset `busy`, `done`, `error`, `flag_clr`, `wr_req` and all PHY control outputs are 0.
- R2: A start pulse is accepted only while idle. Start pulses while `busy` is high have no effect: the run keeps its latched pixel clock and produces a single `done`.
- R3: Opening order of each pass, one step per cycle: data-enable polarity select on, interface select off, TMDS enable off and PHY power off (all in one step); transmit power off; quiescent on; `phy_reset` high for exactly one cycle; `test_clr` high; `slave_load` high for one cycle; `test_clr` low. All of this happens before the pass's first write. `wr_req` is only ever high while `quiescent`=1, `tx_power`=0 and `test_clr`=0.
- R4: Each pass issues 9 writes in this order. Each write is preceded by a one-cycle `flag_clr` pulse, then `wr_req` rises. `wr_addr`/`wr_data` are held until `wr_ack` or `wr_err`, and either of these ends the wait and lets the sequence continue. The fixed writes are: third after band words, address 0x13 ← 0x0000; 0x17 ← 0x0006; 0x19 ← 0x0004; 0x05 ← 0x8000.
- R5: The first two writes are the charge-pump word at address 0x06 and the gain word at address 0x15. For bands ≤45250 kHz, ≤92500 kHz, ≤185000 kHz and above, the charge-pump word is 0x00B3, 0x0072, 0x0051 or 0x0040, and the gain word is 0x0000, 0x0008, 0x001B or 0x0036.
- R6: The third write is the current word at address 0x10: 0x091C up to 58400 kHz, 0x06DC up to 74250 kHz, 0x091C up to 118800 kHz and 0x06DC up to 216000 kHz.
- R7: The last two writes are the symbol word at 0x09 and the level word at 0x0E. Above 148500 kHz they are 0x800D and 0x0129 (level 9). At or below 148500 kHz they are 0x800B and 0x01AD (level 13).
- R8: A pixel clock above 216000 kHz gives an `error` pulse on the cycle after start, with no busy cycle and no write.
- R9: After the writes, each pass raises PHY power, holds TMDS enable low for one step and then raises it, raises transmit power and releases quiescent, one step each and in that order, before lock polling starts.
- R10: The lock indicator is sampled at the start of lock wait and then every LOCK_POLL cycles. If it is still low after LOCK_RETRIES retries and one further poll interval, the run ends in error.
- R11: The whole pass runs twice, giving 18 writes and two reset pulses, and then `done` pulses once.
- R12: A write not answered within WR_TIMEOUT cycles aborts the run with `error`. No further write follows, and `pwr_en` and `tx_power` are 0.
- R13: `done` and `error` are one-cycle pulses, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| pix_khz | input | KHZ_W | Requested pixel clock in kHz |
| busy | output | 1 | Program running |
| done | output | 1 | Successful completion pulse |
| error | output | 1 | Failure pulse |
| den_pol_sel | output | 1 | Data-enable polarity select to PHY |
| if_sel | output | 1 | PHY interface select |
| pwr_en | output | 1 | PHY power enable |
| tmds_en | output | 1 | TMDS output enable |
| tx_power | output | 1 | Transmit power on |
| quiescent | output | 1 | Quiescent (power-down) mode |
| phy_reset | output | 1 | PHY reset pulse |
| test_clr | output | 1 | PHY test-clear |
| slave_load | output | 1 | Load PHY slave address strobe |
| flag_clr | output | 1 | Clear completion and error flags before a write |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 8 | Register address |
| wr_data | output | 16 | Register value |
| wr_ack | input | 1 | Write completed flag |
| wr_err | input | 1 | Write error flag |
| pll_lock | input | 1 | PHY PLL lock indicator |

## Verification
Every control output is registered. Each step therefore shows at the ports one cycle after the step's state is entered. `done` and `error` appear on the cycle after the final lock sample or the failing event. For an unsupported clock, `error` appears on the cycle right after start. The bench samples on the falling edge and records every output change in a per-cycle event log. Ordering is checked against that log rather than against absolute cycle numbers. A run is awaited until its `done` or `error` falling-edge sample. `busy` is checked in that sample and the pulse's end in the next one. Write contents are captured at the sample where `wr_req` is first seen high, and acknowledges are returned a fixed number of samples later.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int NUM_WR  = 9;
    localparam int IDX_W   = $clog2(NUM_WR);
    localparam int MAX_KHZ = 216000;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } phy_wr_t;

    typedef enum logic [4:0] {
        S_IDLE, S_PRE, S_TXOFF, S_QUIET, S_RST_ON, S_RST_OFF, S_TC_SET,
        S_SLAVE, S_TC_REL, S_WR_GO, S_WR_WAIT, S_PWR, S_TMDS_LO,
        S_TMDS_HI, S_TXON, S_QREL, S_LOCK_GO, S_LOCK_WAIT
    } seq_st_e;

    function automatic logic [1:0] pll_band(input logic [31:0] khz);
        if (khz <= 32'd45250)       return 2'd0;
        else if (khz <= 32'd92500)  return 2'd1;
        else if (khz <= 32'd185000) return 2'd2;
        else                        return 2'd3;
    endfunction

    function automatic logic [15:0] curr_word(input logic [31:0] khz);
        if (khz <= 32'd58400)       return 16'h091C;
        else if (khz <= 32'd74250)  return 16'h06DC;
        else if (khz <= 32'd118800) return 16'h091C;
        else                        return 16'h06DC;
    endfunction

    function automatic logic fast_sym(input logic [31:0] khz);
        return khz > 32'd148500;
    endfunction

endpackage

// File: rtl/phy_cfg_table.sv
module phy_cfg_table
    import phy_seq_pkg::*;
#(
    parameter int KHZ_W = 18
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [KHZ_W-1:0] khz,
    output phy_wr_t          entry
);
    logic [31:0] khz32;
    logic [1:0]  band;
    logic        fast;

    assign khz32 = {{(32-KHZ_W){1'b0}}, khz};
    assign band  = pll_band(khz32);
    assign fast  = fast_sym(khz32);

    always_comb begin
        entry = '{addr: 8'h00, data: 16'h0000};
        case (idx)
            4'd0: begin
                entry.addr = 8'h06;
                case (band)
                    2'd0:    entry.data = 16'h00B3;
                    2'd1:    entry.data = 16'h0072;
                    2'd2:    entry.data = 16'h0051;
                    default: entry.data = 16'h0040;
                endcase
            end
            4'd1: begin
                entry.addr = 8'h15;
                case (band)
                    2'd0:    entry.data = 16'h0000;
                    2'd1:    entry.data = 16'h0008;
                    2'd2:    entry.data = 16'h001B;
                    default: entry.data = 16'h0036;
                endcase
            end
            4'd2: entry = '{addr: 8'h10, data: curr_word(khz32)};
            4'd3: entry = '{addr: 8'h13, data: 16'h0000};
            4'd4: entry = '{addr: 8'h17, data: 16'h0006};
            4'd5: entry = '{addr: 8'h19, data: 16'h0004};
            4'd6: entry = '{addr: 8'h05, data: 16'h8000};
            4'd7: entry = '{addr: 8'h09, data: fast ? 16'h800D : 16'h800B};
            4'd8: entry = '{addr: 8'h0E, data: fast ? 16'h0129 : 16'h01AD};
            default: entry = '{addr: 8'h00, data: 16'h0000};
        endcase
    end
endmodule

// File: rtl/phy_wr_port.sv
module phy_wr_port #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic ack,
    input  logic err,
    output logic flag_clr,
    output logic req,
    output logic fin,
    output logic tmo
);
    localparam int TMO_W = $clog2(TIMEOUT + 1);

    typedef enum logic [1:0] {W_IDLE, W_CLR, W_REQ} wr_st_e;

    wr_st_e           st;
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= W_IDLE; cnt <= '0; flag_clr <= 1'b0;
            req <= 1'b0; fin <= 1'b0; tmo <= 1'b0;
        end else begin
            fin <= 1'b0;
            tmo <= 1'b0;
            case (st)
                W_IDLE: if (go) begin
                    flag_clr <= 1'b1;
                    st       <= W_CLR;
                end
                W_CLR: begin
                    flag_clr <= 1'b0;
                    req      <= 1'b1;
                    cnt      <= '0;
                    st       <= W_REQ;
                end
                W_REQ: begin
                    if (ack || err) begin
                        req <= 1'b0; fin <= 1'b1; st <= W_IDLE;
                    end else if (cnt == TMO_W'(TIMEOUT - 1)) begin
                        req <= 1'b0; fin <= 1'b1; tmo <= 1'b1; st <= W_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // R4: flags are cleared on the cycle before each request rises
    assert_clr_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(flag_clr));

    // R4: an answered request ends cleanly, without a timeout
    assert_answer_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (req && (ack || err)) |=> (fin && !tmo && !req));
endmodule

// File: rtl/phy_lock_poll.sv
module phy_lock_poll #(
    parameter int POLL    = 1000,
    parameter int RETRIES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic pll_lock,
    output logic ok,
    output logic fail
);
    localparam int CNT_W = $clog2(POLL + 1);
    localparam int TRY_W = $clog2(RETRIES + 1);

    logic             act;
    logic [CNT_W-1:0] cnt;
    logic [TRY_W-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0; cnt <= '0; tries <= '0; ok <= 1'b0; fail <= 1'b0;
        end else begin
            ok   <= 1'b0;
            fail <= 1'b0;
            if (go) begin
                act <= 1'b1; cnt <= '0; tries <= '0;
            end else if (act) begin
                if (cnt == '0 && pll_lock) begin
                    ok <= 1'b1; act <= 1'b0;
                end else if (cnt == CNT_W'(POLL - 1)) begin
                    cnt <= '0;
                    if (tries == TRY_W'(RETRIES)) begin
                        fail <= 1'b1; act <= 1'b0;
                    end else begin
                        tries <= tries + 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10: success is only reported after lock was seen
    assert_ok_on_lock_R10: assert property (@(posedge clk) disable iff (rst)
        ok |-> $past(pll_lock));

    // R10: a poll ends in exactly one outcome
    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(ok && fail));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int KHZ_W        = 18,
    parameter int WR_TIMEOUT   = 250_000_000,
    parameter int LOCK_POLL    = 250_000,
    parameter int LOCK_RETRIES = 4,
    parameter int PASSES       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [KHZ_W-1:0] pix_khz,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             den_pol_sel,
    output logic             if_sel,
    output logic             pwr_en,
    output logic             tmds_en,
    output logic             tx_power,
    output logic             quiescent,
    output logic             phy_reset,
    output logic             test_clr,
    output logic             slave_load,
    output logic             flag_clr,
    output logic             wr_req,
    output logic [7:0]       wr_addr,
    output logic [15:0]      wr_data,
    input  logic             wr_ack,
    input  logic             wr_err,
    input  logic             pll_lock
);
    localparam int PASS_W = $clog2(PASSES + 1);

    seq_st_e           state;
    logic [KHZ_W-1:0]  pix_q;
    logic [IDX_W-1:0]  idx;
    logic [PASS_W-1:0] pass;
    phy_wr_t           cur;
    logic              wr_fin, wr_tmo, lock_ok, lock_fail;
    logic              unsupported;

    assign busy        = (state != S_IDLE);
    assign unsupported = ({{(32-KHZ_W){1'b0}}, pix_khz} > 32'(MAX_KHZ));
    assign wr_addr     = cur.addr;
    assign wr_data     = cur.data;

    phy_cfg_table #(.KHZ_W(KHZ_W)) u_table (
        .idx(idx), .khz(pix_q), .entry(cur)
    );

    phy_wr_port #(.TIMEOUT(WR_TIMEOUT)) u_wr (
        .clk(clk), .rst(rst), .go(state == S_WR_GO), .ack(wr_ack), .err(wr_err),
        .flag_clr(flag_clr), .req(wr_req), .fin(wr_fin), .tmo(wr_tmo)
    );

    phy_lock_poll #(.POLL(LOCK_POLL), .RETRIES(LOCK_RETRIES)) u_lock (
        .clk(clk), .rst(rst), .go(state == S_LOCK_GO), .pll_lock(pll_lock),
        .ok(lock_ok), .fail(lock_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; pix_q <= '0; idx <= '0; pass <= '0;
            done <= 1'b0; error <= 1'b0;
            den_pol_sel <= 1'b0; if_sel <= 1'b0; pwr_en <= 1'b0; tmds_en <= 1'b0;
            tx_power <= 1'b0; quiescent <= 1'b0; phy_reset <= 1'b0;
            test_clr <= 1'b0; slave_load <= 1'b0;
        end else begin
            done       <= 1'b0;
            error      <= 1'b0;
            slave_load <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    pix_q <= pix_khz; pass <= '0; idx <= '0;
                    if (unsupported) begin
                        error <= 1'b1; pwr_en <= 1'b0; tx_power <= 1'b0;
                    end else begin
                        state <= S_PRE;
                    end
                end
                S_PRE: begin
                    den_pol_sel <= 1'b1; if_sel <= 1'b0;
                    tmds_en <= 1'b0; pwr_en <= 1'b0;
                    state <= S_TXOFF;
                end
                S_TXOFF:   begin tx_power  <= 1'b0; state <= S_QUIET;   end
                S_QUIET:   begin quiescent <= 1'b1; state <= S_RST_ON;  end
                S_RST_ON:  begin phy_reset <= 1'b1; state <= S_RST_OFF; end
                S_RST_OFF: begin phy_reset <= 1'b0; state <= S_TC_SET;  end
                S_TC_SET:  begin test_clr  <= 1'b1; state <= S_SLAVE;   end
                S_SLAVE:   begin slave_load <= 1'b1; state <= S_TC_REL; end
                S_TC_REL:  begin test_clr  <= 1'b0; state <= S_WR_GO;   end
                S_WR_GO:   state <= S_WR_WAIT;
                S_WR_WAIT: if (wr_fin) begin
                    if (wr_tmo) begin
                        error <= 1'b1; pwr_en <= 1'b0; tx_power <= 1'b0;
                        state <= S_IDLE;
                    end else if (idx == IDX_W'(NUM_WR - 1)) begin
                        idx <= '0; state <= S_PWR;
                    end else begin
                        idx <= idx + 1'b1; state <= S_WR_GO;
                    end
                end
                S_PWR:     begin pwr_en    <= 1'b1; state <= S_TMDS_LO; end
                S_TMDS_LO: begin tmds_en   <= 1'b0; state <= S_TMDS_HI; end
                S_TMDS_HI: begin tmds_en   <= 1'b1; state <= S_TXON;    end
                S_TXON:    begin tx_power  <= 1'b1; state <= S_QREL;    end
                S_QREL:    begin quiescent <= 1'b0; state <= S_LOCK_GO; end
                S_LOCK_GO: state <= S_LOCK_WAIT;
                S_LOCK_WAIT: begin
                    if (lock_fail) begin
                        error <= 1'b1; pwr_en <= 1'b0; tx_power <= 1'b0;
                        state <= S_IDLE;
                    end else if (lock_ok) begin
                        if (pass == PASS_W'(PASSES - 1)) begin
                            done <= 1'b1; state <= S_IDLE;
                        end else begin
                            pass <= pass + 1'b1; state <= S_PRE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R13: result pulses appear with busy already low
    assert_pulse_idle_R13: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);

    // R13: done lasts one cycle and never coincides with error
    assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_result_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R3: writes only go out while the PHY is quiescent with transmit power off
    assert_wr_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (quiescent && !tx_power && !test_clr));

    // R4: address and value hold while a request is pending
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && $past(wr_req)) |-> ($stable(wr_addr) && $stable(wr_data)));

    // R9: lock polling runs only with the PHY fully powered and transmitting
    assert_lock_powered_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOCK_WAIT) |-> (pwr_en && tmds_en && tx_power && !quiescent));

    // R12: a failing run leaves PHY and transmit power off
    assert_err_power_off_R12: assert property (@(posedge clk) disable iff (rst)
        error |-> (!pwr_en && !tx_power));
endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
    localparam int KHZ_W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [KHZ_W-1:0] pix_khz = '0;
    logic busy, done, error, den_pol_sel, if_sel, pwr_en, tmds_en, tx_power;
    logic quiescent, phy_reset, test_clr, slave_load, flag_clr, wr_req;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic wr_ack = 1'b0, wr_err = 1'b0, pll_lock = 1'b0;

    int checks = 0, fails = 0;

    // responder and lock model controls
    int ack_dly = 1, err_idx = -1, hang_idx = -1;
    bit lock_en = 1'b1;
    int lock_dly = 2;

    // observations
    string lg;
    int wr_n, done_n, err_n;
    int wa [64];
    int wd [64];

    always #2 clk = ~clk;

    phy_bringup_seq #(.KHZ_W(KHZ_W), .WR_TIMEOUT(20), .LOCK_POLL(8),
                      .LOCK_RETRIES(4), .PASSES(2)) i_phy_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .pix_khz(pix_khz),
        .busy(busy), .done(done), .error(error),
        .den_pol_sel(den_pol_sel), .if_sel(if_sel), .pwr_en(pwr_en),
        .tmds_en(tmds_en), .tx_power(tx_power), .quiescent(quiescent),
        .phy_reset(phy_reset), .test_clr(test_clr), .slave_load(slave_load),
        .flag_clr(flag_clr), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err), .pll_lock(pll_lock)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor, event log, write responder and lock model, all on the falling edge
    initial begin
        logic p_d, p_i, p_m, p_p, p_x, p_q, p_r, p_s, p_t, p_c, p_w;
        int rcnt, cur_idx, lock_cnt;
        {p_d, p_i, p_m, p_p, p_x, p_q, p_r, p_s, p_t, p_c, p_w} = '0;
        rcnt = 0; cur_idx = 0; lock_cnt = 0;
        lg = ""; wr_n = 0; done_n = 0; err_n = 0;
        forever begin
            @(negedge clk);
            wr_ack = 1'b0;
            wr_err = 1'b0;
            if (rst) begin
                lg = ""; wr_n = 0; done_n = 0; err_n = 0; rcnt = 0;
            end else begin
                if (den_pol_sel != p_d) lg = {lg, den_pol_sel ? "D" : "d"};
                if (if_sel      != p_i) lg = {lg, if_sel      ? "I" : "i"};
                if (tmds_en     != p_m) lg = {lg, tmds_en     ? "M" : "m"};
                if (pwr_en      != p_p) lg = {lg, pwr_en      ? "P" : "p"};
                if (tx_power    != p_x) lg = {lg, tx_power    ? "X" : "x"};
                if (quiescent   != p_q) lg = {lg, quiescent   ? "Q" : "q"};
                if (phy_reset   != p_r) lg = {lg, phy_reset   ? "R" : "r"};
                if (slave_load  != p_s) lg = {lg, slave_load  ? "S" : "s"};
                if (test_clr    != p_t) lg = {lg, test_clr    ? "T" : "t"};
                if (flag_clr && !p_c) lg = {lg, "C"};
                if (wr_req && !p_w) begin
                    lg = {lg, "W"};
                    cur_idx = wr_n;
                    if (wr_n < 64) begin wa[wr_n] = int'(wr_addr); wd[wr_n] = int'(wr_data); end
                    wr_n++;
                    rcnt = 0;
                end
                if (done)  done_n++;
                if (error) err_n++;
                if (wr_req && (cur_idx % 9) != hang_idx) begin
                    if (rcnt >= ack_dly) begin
                        if ((cur_idx % 9) == err_idx) wr_err = 1'b1;
                        else wr_ack = 1'b1;
                    end
                    rcnt++;
                end
            end
            {p_d, p_i, p_m, p_p, p_x, p_q, p_r, p_s, p_t, p_c, p_w} =
                {den_pol_sel, if_sel, tmds_en, pwr_en, tx_power, quiescent,
                 phy_reset, slave_load, test_clr, flag_clr, wr_req};
            if (tx_power && !quiescent) lock_cnt++;
            else lock_cnt = 0;
            pll_lock = lock_en && (lock_cnt >= lock_dly);
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic reset_dut();
        ack_dly = 1; err_idx = -1; hang_idx = -1; lock_en = 1'b1; lock_dly = 2;
        start = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Launch a run and wait for its result; checks the result pulse shape (R13)
    task automatic run(input int khz, input bit extra, output int busy_cyc);
        busy_cyc = 0;
        pix_khz = KHZ_W'(khz);
        start = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (extra && (k == 10 || k == 40)) begin
                start = 1'b1; pix_khz = KHZ_W'(250000);
            end
            if (busy) busy_cyc++;
            if (done || error) break;
        end
        chk(done || error, "R13", "run finished", {done, error}, 1);
        chk(!busy, "R13", "busy low with result pulse", busy, 0);
        @(negedge clk);
        start = 1'b0;
        chk(!done && !error, "R13", "result pulse one cycle", {done, error}, 0);
    endtask

    function automatic void exp_wr(input int i, input int k, output int a, output int d);
        int b;
        b = (k <= 45250) ? 0 : (k <= 92500) ? 1 : (k <= 185000) ? 2 : 3;
        case (i)
            0: begin a = 'h06; d = (b == 0) ? 'h00B3 : (b == 1) ? 'h0072 : (b == 2) ? 'h0051 : 'h0040; end
            1: begin a = 'h15; d = (b == 0) ? 'h0000 : (b == 1) ? 'h0008 : (b == 2) ? 'h001B : 'h0036; end
            2: begin a = 'h10; d = (k <= 58400) ? 'h091C : (k <= 74250) ? 'h06DC :
                                   (k <= 118800) ? 'h091C : 'h06DC; end
            3: begin a = 'h13; d = 'h0000; end
            4: begin a = 'h17; d = 'h0006; end
            5: begin a = 'h19; d = 'h0004; end
            6: begin a = 'h05; d = 'h8000; end
            7: begin a = 'h09; d = (k > 148500) ? 'h800D : 'h800B; end
            default: begin a = 'h0E; d = (k > 148500) ? 'h0129 : 'h01AD; end
        endcase
    endfunction

    function automatic string exp_log();
        string w, s;
        w = "";
        for (int i = 0; i < 9; i++) w = {w, "CW"};
        s = {"DQRrTSst", w, "PMXq", "mpxQRrTSst", w, "PMXq"};
        return s;
    endfunction

    // Compare captured writes of a full run against the band tables (R5, R6, R7, R4)
    task automatic check_writes(input int khz);
        int bad5, bad6, bad7, bad4, a, d, i;
        bad5 = 0; bad6 = 0; bad7 = 0; bad4 = 0;
        chk(wr_n == 18, "R11", "write count", wr_n, 18);
        for (int n = 0; n < 18 && n < wr_n; n++) begin
            i = n % 9;
            exp_wr(i, khz, a, d);
            if (wa[n] != a || wd[n] != d) begin
                if (i < 2) bad5++;
                else if (i == 2) bad6++;
                else if (i >= 7) bad7++;
                else bad4++;
                $display("  write %0d at %0d kHz: got %02h<-%04h want %02h<-%04h",
                         n, khz, wa[n], wd[n], a, d);
            end
        end
        chk(bad5 == 0, "R5", $sformatf("pump/gain words %0d kHz", khz), bad5, 0);
        chk(bad6 == 0, "R6", $sformatf("current word %0d kHz", khz), bad6, 0);
        chk(bad7 == 0, "R7", $sformatf("symbol/level words %0d kHz", khz), bad7, 0);
        chk(bad4 == 0, "R4", $sformatf("fixed writes %0d kHz", khz), bad4, 0);
    endtask

    task automatic t_reset();
        reset_dut();
        chk({busy, done, error, flag_clr, wr_req} == 5'b0, "R1", "status after reset",
            {busy, done, error, flag_clr, wr_req}, 0);
        chk({den_pol_sel, if_sel, pwr_en, tmds_en, tx_power, quiescent, phy_reset,
             test_clr, slave_load} == 9'b0, "R1", "PHY controls after reset",
            {den_pol_sel, if_sel, pwr_en, tmds_en, tx_power, quiescent, phy_reset,
             test_clr, slave_load}, 0);
    endtask

    task automatic t_full(input int khz);
        int bc;
        reset_dut();
        run(khz, 1'b0, bc);
        chk(done_n == 1 && err_n == 0, "R11", $sformatf("one done at %0d kHz", khz),
            done_n * 16 + err_n, 16);
        chk(lg == exp_log(), "R3", $sformatf("step order at %0d kHz", khz), lg.len(), exp_log().len());
        if (lg != exp_log()) $display("  log %s\n  exp %s", lg, exp_log());
        check_writes(khz);
        chk({pwr_en, tmds_en, tx_power, quiescent} == 4'b1110, "R9", "final PHY state",
            {pwr_en, tmds_en, tx_power, quiescent}, 4'b1110);
    endtask

    task automatic t_unsupported();
        int bc;
        reset_dut();
        pix_khz = KHZ_W'(216001);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(error && !busy, "R8", "error on next cycle", {error, busy}, 2'b10);
        repeat (10) @(negedge clk);
        chk(wr_n == 0 && done_n == 0, "R8", "no writes, no done", wr_n, 0);
        chk(!pwr_en && !tx_power, "R8", "power stays off", {pwr_en, tx_power}, 0);
        run(216000, 1'b0, bc);
        chk(done_n == 1, "R8", "216000 kHz still supported", done_n, 1);
    endtask

    task automatic t_wr_err();
        int bc;
        reset_dut();
        err_idx = 2;
        run(60000, 1'b0, bc);
        chk(done_n == 1 && err_n == 0, "R4", "error flag ends wait, run completes",
            done_n, 1);
        check_writes(60000);
    endtask

    task automatic t_slow_ack();
        int bc;
        reset_dut();
        ack_dly = 6;
        run(120000, 1'b0, bc);
        chk(done_n == 1, "R4", "slow acknowledge completes", done_n, 1);
        check_writes(120000);
    endtask

    task automatic t_busy_start();
        int bc;
        reset_dut();
        run(40000, 1'b1, bc);
        chk(done_n == 1, "R2", "single done with extra starts", done_n, 1);
        check_writes(40000);
        repeat (30) @(negedge clk);
        chk(wr_n == 18 && !busy, "R2", "no rerun after extra starts", wr_n, 18);
    endtask

    task automatic t_wr_tmo();
        int bc;
        reset_dut();
        hang_idx = 3;
        run(100000, 1'b0, bc);
        chk(err_n == 1 && done_n == 0, "R12", "timeout reports error", err_n, 1);
        repeat (40) @(negedge clk);
        chk(wr_n == 4, "R12", "no write after timeout", wr_n, 4);
        chk(!pwr_en && !tx_power && !busy, "R12", "power off after timeout",
            {pwr_en, tx_power, busy}, 0);
    endtask

    task automatic t_lock_late();
        int bc;
        reset_dut();
        lock_dly = 20;
        run(74250, 1'b0, bc);
        chk(done_n == 1 && err_n == 0, "R10", "late lock inside poll window", done_n, 1);
    endtask

    task automatic t_lock_never();
        int bc;
        reset_dut();
        lock_en = 1'b0;
        run(74250, 1'b0, bc);
        chk(err_n == 1 && done_n == 0, "R10", "no lock gives error", err_n, 1);
        chk(wr_n == 9, "R10", "error in first pass", wr_n, 9);
        chk(!pwr_en && !tx_power, "R12", "power off after lock failure",
            {pwr_en, tx_power}, 0);
    endtask

    initial begin
        t_reset();
        t_full(40000);
        t_full(45250);
        t_full(45251);
        t_full(74250);
        t_full(100000);
        t_full(148500);
        t_full(150000);
        t_full(200000);
        t_unsupported();
        t_wr_err();
        t_slow_ack();
        t_busy_start();
        t_wr_tmo();
        t_lock_late();
        t_lock_never();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule